// File: doc/BRIEF.md
# Pipeline Stall Controller

This block decides, every cycle, whether a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back) may advance. It has no forwarding network, so the decode stage must wait until every older instruction that writes one of its source registers has reached write-back. The register file is assumed to write in the first half of a cycle and to be read in the second half. A result in write-back is therefore already visible to decode.

While a dependency is open, the controller freezes the program counter and the fetch/decode register and sends an all-zero NOP control word into the decode/execute register. Conditional branches are resolved in execute, and no branch predictor is used. When a branch leaves decode, the controller stops fetch advancing. It also replaces the fetch/decode contents with a NOP for that cycle and for the following cycle, while the branch sits in execute. After that, fetch continues from the held fall-through address or from the redirect target, which the datapath applies with priority over the hold.

A one-bit register records that a branch has moved into execute. All other outputs are combinational functions of the current stage contents, so they are valid in the same cycle as their inputs.

Top module: `hzd_stall_unit`

## Requirements
- R1: A synchronous active-high reset clears the branch-tracking state. After reset, with no source enabled and no branch in decode, all four control outputs are 0, even if a branch was in decode while reset was asserted.
- R2: If an enabled decode source index equals the execute-stage destination index, that destination is write-enabled, and the index is nonzero, then in the same cycle `fetch_hold`=1, `decode_hold`=1, `issue_bubble`=1 and `decode_flush`=0.
- R3: The same stall as R2 is raised when the matching write-enabled nonzero destination belongs to the memory stage.
- R4: Register index 0 never causes a stall, whatever the enables and source indices are.
- R5: No stall is raised when the matching source is disabled, when the producer's write enable is low, or when the indices differ.
- R6: A consumer directly behind a producer is held for exactly two cycles: first with the producer in execute, then with it in memory. It issues in the third cycle, because a write-back result needs no stall.
- R7: With a branch in decode and no data stall, in the same cycle `fetch_hold`=1, `decode_flush`=1, `decode_hold`=0 and `issue_bubble`=0.
- R8: In the cycle after a branch leaves decode (branch in decode and no data stall at the clock edge), `fetch_hold`=1 and `decode_flush`=1. In the cycle after that, with quiet inputs, all outputs are 0.
- R9: A data stall takes priority over a branch in decode: the outputs are those of R2/R3 with `decode_flush`=0. The branch is not treated as having left decode until a cycle without a stall.
- R10: A pipeline driven by these controls leaves the same architectural register contents as one-at-a-time sequential execution of the same program. This holds for programs with add, add-immediate, load and taken or untaken forward branches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_a_idx | input | REG_W | First source register index of the decode instruction |
| src_a_en | input | 1 | First source is actually read |
| src_b_idx | input | REG_W | Second source register index of the decode instruction |
| src_b_en | input | 1 | Second source is actually read |
| id_branch | input | 1 | Decode instruction is a conditional branch |
| ex_dst_idx | input | REG_W | Destination index of the execute-stage instruction |
| ex_dst_wen | input | 1 | Execute-stage instruction writes a register |
| mem_dst_idx | input | REG_W | Destination index of the memory-stage instruction |
| mem_dst_wen | input | 1 | Memory-stage instruction writes a register |
| fetch_hold | output | 1 | Keep the program counter (a branch redirect overrides) |
| decode_hold | output | 1 | Keep the fetch/decode register |
| decode_flush | output | 1 | Load a NOP into the fetch/decode register |
| issue_bubble | output | 1 | Load an all-zero NOP control word into decode/execute |

## Verification
The data-hazard results (R2 to R5, R7, R9) are combinational. The bench drives each pattern on the falling edge and samples one nanosecond later, in the same cycle. The branch-shadow result (R8) depends on the clock edge that follows a branch leaving decode, so it is sampled on the next falling edge. R6 is checked over three successive cycles as the producer moves from execute to memory and then out. In the program runs, a bench pipeline applies the controls sampled in one cycle at the next falling edge and compares register contents only after a drain period long enough for every instruction to retire.

// File: rtl/hzd_pkg.sv
`timescale 1ns/1ps
package hzd_pkg;

  // Number of decode-stage source operands and of producer stages that can
  // still hold an unwritten result (execute and memory).
  localparam int NUM_SRC  = 2;
  localparam int NUM_PROD = 2;

  typedef enum int {
    SRC_A = 0,
    SRC_B = 1
  } src_port_e;

  typedef enum int {
    PROD_EX  = 0,
    PROD_MEM = 1
  } prod_stage_e;

endpackage

// File: rtl/hzd_match.sv
`timescale 1ns/1ps
// One source/producer comparison: a hit means the source would read a value
// that the producer has not yet written into the register file.
module hzd_match #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_idx,
  input  logic             src_en,
  input  logic [REG_W-1:0] dst_idx,
  input  logic             dst_wen,
  output logic             hit
);

  logic dst_live;

  always_comb begin
    dst_live = dst_wen && (dst_idx != '0);
    hit      = src_en && dst_live && (src_idx == dst_idx);
  end

endmodule

// File: rtl/hzd_data_detect.sv
`timescale 1ns/1ps
// Grid of comparators: every source against every producer stage.
module hzd_data_detect #(
  parameter int REG_W = 5,
  parameter int NSRC  = 2,
  parameter int NPROD = 2
) (
  input  logic [NSRC-1:0][REG_W-1:0]  src_idx,
  input  logic [NSRC-1:0]             src_en,
  input  logic [NPROD-1:0][REG_W-1:0] dst_idx,
  input  logic [NPROD-1:0]            dst_wen,
  output logic                        stall
);

  localparam int NPAIR = NSRC * NPROD;

  logic [NPAIR-1:0] hit;

  genvar s, p;
  generate
    for (s = 0; s < NSRC; s++) begin : g_src
      for (p = 0; p < NPROD; p++) begin : g_prod
        hzd_match #(
          .REG_W (REG_W)
        ) u_match (
          .src_idx (src_idx[s]),
          .src_en  (src_en[s]),
          .dst_idx (dst_idx[p]),
          .dst_wen (dst_wen[p]),
          .hit     (hit[s*NPROD + p])
        );
      end
    end
  endgenerate

  always_comb stall = |hit;

endmodule

// File: rtl/hzd_branch_track.sv
`timescale 1ns/1ps
// Tracks the branch shadow: the cycle a branch is in decode and the cycle it
// spends in execute, during which fetch must not deliver a real instruction.
module hzd_branch_track (
  input  logic clk,
  input  logic rst,
  input  logic id_branch,
  input  logic data_stall,
  output logic fetch_hold,
  output logic decode_flush
);

  logic br_in_ex;
  logic br_pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      br_in_ex <= 1'b0;
    end else begin
      // The branch advances into execute only on a cycle without a data stall.
      br_in_ex <= id_branch && !data_stall;
    end
  end

  always_comb begin
    br_pending   = id_branch || br_in_ex;
    decode_flush = br_pending && !data_stall;
    fetch_hold   = br_pending || data_stall;
  end

endmodule

// File: rtl/hzd_stall_unit.sv
`timescale 1ns/1ps
module hzd_stall_unit
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] src_a_idx,
  input  logic             src_a_en,
  input  logic [REG_W-1:0] src_b_idx,
  input  logic             src_b_en,
  input  logic             id_branch,
  input  logic [REG_W-1:0] ex_dst_idx,
  input  logic             ex_dst_wen,
  input  logic [REG_W-1:0] mem_dst_idx,
  input  logic             mem_dst_wen,
  output logic             fetch_hold,
  output logic             decode_hold,
  output logic             decode_flush,
  output logic             issue_bubble
);

  logic [NUM_SRC-1:0][REG_W-1:0]  src_idx;
  logic [NUM_SRC-1:0]             src_en;
  logic [NUM_PROD-1:0][REG_W-1:0] dst_idx;
  logic [NUM_PROD-1:0]            dst_wen;
  logic                           data_stall;
  logic                           br_fetch_hold;
  logic                           br_flush;

  always_comb begin
    src_idx[SRC_A]   = src_a_idx;
    src_idx[SRC_B]   = src_b_idx;
    src_en[SRC_A]    = src_a_en;
    src_en[SRC_B]    = src_b_en;
    dst_idx[PROD_EX] = ex_dst_idx;
    dst_idx[PROD_MEM]= mem_dst_idx;
    dst_wen[PROD_EX] = ex_dst_wen;
    dst_wen[PROD_MEM]= mem_dst_wen;
  end

  hzd_data_detect #(
    .REG_W (REG_W),
    .NSRC  (NUM_SRC),
    .NPROD (NUM_PROD)
  ) u_detect (
    .src_idx (src_idx),
    .src_en  (src_en),
    .dst_idx (dst_idx),
    .dst_wen (dst_wen),
    .stall   (data_stall)
  );

  hzd_branch_track u_branch (
    .clk          (clk),
    .rst          (rst),
    .id_branch    (id_branch),
    .data_stall   (data_stall),
    .fetch_hold   (br_fetch_hold),
    .decode_flush (br_flush)
  );

  always_comb begin
    decode_hold  = data_stall;
    issue_bubble = data_stall;
    fetch_hold   = br_fetch_hold;
    decode_flush = br_flush;
  end

endmodule

// File: rtl/hzd_stall_unit_chk.sv
`timescale 1ns/1ps
module hzd_stall_unit_chk #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [REG_W-1:0] src_a_idx,
  input logic             src_a_en,
  input logic [REG_W-1:0] src_b_idx,
  input logic             src_b_en,
  input logic             id_branch,
  input logic [REG_W-1:0] ex_dst_idx,
  input logic             ex_dst_wen,
  input logic [REG_W-1:0] mem_dst_idx,
  input logic             mem_dst_wen,
  input logic             fetch_hold,
  input logic             decode_hold,
  input logic             decode_flush,
  input logic             issue_bubble
);

  AST_EX_SRC_A_STALL: assert property (@(posedge clk) disable iff (rst)
    (src_a_en && ex_dst_wen && ex_dst_idx != '0 && src_a_idx == ex_dst_idx)
    |-> (decode_hold && issue_bubble && fetch_hold)); // R2

  AST_MEM_SRC_B_STALL: assert property (@(posedge clk) disable iff (rst)
    (src_b_en && mem_dst_wen && mem_dst_idx != '0 && src_b_idx == mem_dst_idx)
    |-> (decode_hold && issue_bubble && fetch_hold)); // R3

  AST_ZERO_DST_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ex_dst_idx == '0 && mem_dst_idx == '0) |-> !issue_bubble); // R4

  AST_NO_SRC_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!src_a_en && !src_b_en) |-> !decode_hold); // R5

  AST_BRANCH_ID_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (id_branch && !decode_hold) |-> (fetch_hold && decode_flush)); // R7

  AST_BRANCH_SHADOW: assert property (@(posedge clk) disable iff (rst)
    (id_branch && !decode_hold) |=> (fetch_hold && (decode_flush || decode_hold))); // R8

  AST_STALL_NO_FLUSH: assert property (@(posedge clk) disable iff (rst)
    decode_hold |-> !decode_flush); // R9

endmodule

bind hzd_stall_unit hzd_stall_unit_chk #(.REG_W(REG_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .src_a_idx    (src_a_idx),
  .src_a_en     (src_a_en),
  .src_b_idx    (src_b_idx),
  .src_b_en     (src_b_en),
  .id_branch    (id_branch),
  .ex_dst_idx   (ex_dst_idx),
  .ex_dst_wen   (ex_dst_wen),
  .mem_dst_idx  (mem_dst_idx),
  .mem_dst_wen  (mem_dst_wen),
  .fetch_hold   (fetch_hold),
  .decode_hold  (decode_hold),
  .decode_flush (decode_flush),
  .issue_bubble (issue_bubble)
);

// File: tb/sim_hzd_stall_unit.sv
`timescale 1ns/1ps
module sim_hzd_stall_unit;

  localparam int REG_W  = 5;
  localparam int PLEN   = 16;
  localparam int NPROG  = 40;
  localparam int RUNCYC = 70;

  localparam logic [2:0] OP_NOP  = 3'd0;
  localparam logic [2:0] OP_ADDI = 3'd1;
  localparam logic [2:0] OP_ADD  = 3'd2;
  localparam logic [2:0] OP_LW   = 3'd3;
  localparam logic [2:0] OP_BEQ  = 3'd4;

  typedef struct packed {
    logic [2:0] op;
    logic [2:0] rd;
    logic [2:0] rs;
    logic [2:0] rt;
    logic [3:0] imm;
    logic [7:0] pc;
  } ins_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [REG_W-1:0] src_a_idx, src_b_idx, ex_dst_idx, mem_dst_idx;
  logic src_a_en, src_b_en, id_branch, ex_dst_wen, mem_dst_wen;
  logic fetch_hold, decode_hold, decode_flush, issue_bubble;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #2.5 clk = ~clk;

  hzd_stall_unit #(.REG_W(REG_W)) u0 (
    .clk          (clk),
    .rst          (rst),
    .src_a_idx    (src_a_idx),
    .src_a_en     (src_a_en),
    .src_b_idx    (src_b_idx),
    .src_b_en     (src_b_en),
    .id_branch    (id_branch),
    .ex_dst_idx   (ex_dst_idx),
    .ex_dst_wen   (ex_dst_wen),
    .mem_dst_idx  (mem_dst_idx),
    .mem_dst_wen  (mem_dst_wen),
    .fetch_hold   (fetch_hold),
    .decode_hold  (decode_hold),
    .decode_flush (decode_flush),
    .issue_bubble (issue_bubble)
  );

  // Output vector order: {fetch_hold, decode_hold, decode_flush, issue_bubble}
  localparam logic [3:0] O_IDLE   = 4'b0000;
  localparam logic [3:0] O_DATA   = 4'b1101;
  localparam logic [3:0] O_BRANCH = 4'b1010;

  function automatic logic [3:0] outs();
    return {fetch_hold, decode_hold, decode_flush, issue_bubble};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_outs(input string req, input logic [3:0] exp);
    chk(outs() == exp, req, {28'd0, outs()}, {28'd0, exp});
  endtask

  task automatic quiet();
    src_a_idx = '0; src_a_en = 1'b0;
    src_b_idx = '0; src_b_en = 1'b0;
    id_branch = 1'b0;
    ex_dst_idx = '0; ex_dst_wen = 1'b0;
    mem_dst_idx = '0; mem_dst_wen = 1'b0;
  endtask

  // ---------------- program model ----------------
  ins_t        prog [PLEN];
  logic [15:0] gold [8];
  logic [15:0] rf   [8];
  logic [31:0] seed = 32'h1234_5678;

  function automatic logic [31:0] xs(input logic [31:0] v);
    logic [31:0] x = v;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic bit writes(input ins_t i);
    return (i.op == OP_ADDI) || (i.op == OP_ADD) || (i.op == OP_LW);
  endfunction

  function automatic bit uses_rs(input ins_t i);
    return (i.op != OP_NOP);
  endfunction

  function automatic bit uses_rt(input ins_t i);
    return (i.op == OP_ADD) || (i.op == OP_BEQ);
  endfunction

  function automatic logic [15:0] dmem(input logic [15:0] a);
    return a * 16'd7 + 16'd3;
  endfunction

  task automatic gen_prog();
    for (int k = 0; k < PLEN; k++) begin
      seed = xs(seed);
      prog[k].op  = 3'(seed[2:0] % 5);
      prog[k].rd  = seed[5:3];
      prog[k].rs  = seed[8:6];
      prog[k].rt  = seed[11:9];
      prog[k].imm = seed[15:12];
      if (prog[k].op == OP_BEQ) prog[k].imm = 4'(seed[13:12] % 3);
      prog[k].pc  = 8'(k);
    end
  endtask

  task automatic run_iss();
    int pc = 0;
    for (int r = 0; r < 8; r++) gold[r] = '0;
    for (int g = 0; g < 4 * PLEN && pc < PLEN; g++) begin
      ins_t i = prog[pc];
      logic [15:0] a = gold[i.rs];
      logic [15:0] b = gold[i.rt];
      logic [15:0] v = '0;
      int npc = pc + 1;
      case (i.op)
        OP_ADDI: v = a + 16'(i.imm);
        OP_ADD:  v = a + b;
        OP_LW:   v = dmem(a + 16'(i.imm));
        OP_BEQ:  if (a == b) npc = pc + 1 + int'(i.imm);
        default: v = '0;
      endcase
      if (writes(i) && i.rd != 3'd0) gold[i.rd] = v;
      pc = npc;
    end
  endtask

  task automatic run_pipe();
    logic [7:0]  pc = '0;
    ins_t ifid = '0, idex = '0, exmem = '0, memwb = '0;
    logic [15:0] idex_a = '0, idex_b = '0, exmem_v = '0, memwb_v = '0;
    for (int r = 0; r < 8; r++) rf[r] = '0;
    for (int c = 0; c < RUNCYC; c++) begin
      ins_t n_ifid, fetched;
      logic [15:0] a, b, ex_v, mw_v;
      logic [7:0] n_pc;
      bit taken;
      // drive controller from current stage contents
      src_a_idx   = REG_W'(ifid.rs);  src_a_en = uses_rs(ifid);
      src_b_idx   = REG_W'(ifid.rt);  src_b_en = uses_rt(ifid);
      id_branch   = (ifid.op == OP_BEQ);
      ex_dst_idx  = REG_W'(idex.rd);  ex_dst_wen  = writes(idex);
      mem_dst_idx = REG_W'(exmem.rd); mem_dst_wen = writes(exmem);
      #1;
      // write-back in the first half, decode read in the second half
      if (writes(memwb) && memwb.rd != 3'd0) rf[memwb.rd] = memwb_v;
      a = rf[ifid.rs];
      b = rf[ifid.rt];
      taken = 1'b0;
      ex_v  = '0;
      case (idex.op)
        OP_ADDI: ex_v = idex_a + 16'(idex.imm);
        OP_ADD:  ex_v = idex_a + idex_b;
        OP_LW:   ex_v = idex_a + 16'(idex.imm);
        OP_BEQ:  taken = (idex_a == idex_b);
        default: ex_v = '0;
      endcase
      mw_v    = (exmem.op == OP_LW) ? dmem(exmem_v) : exmem_v;
      fetched = (pc < 8'(PLEN)) ? prog[pc] : '0;
      n_ifid  = decode_hold ? ifid : (decode_flush ? '0 : fetched);
      n_pc    = taken ? (idex.pc + 8'd1 + 8'(idex.imm))
                      : (fetch_hold ? pc : pc + 8'd1);
      @(negedge clk);
      memwb = exmem;  memwb_v = mw_v;
      exmem = idex;   exmem_v = ex_v;
      if (issue_bubble) begin
        idex = '0; idex_a = '0; idex_b = '0;
      end else begin
        idex = ifid; idex_a = a; idex_b = b;
      end
      ifid = n_ifid;
      pc   = n_pc;
    end
  endtask

  // ---------------- main sequence ----------------
  initial begin
    quiet();
    repeat (3) @(negedge clk);
    // R1: reset while a branch sits in decode clears the tracker
    id_branch = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    id_branch = 1'b0;
    #1 chk_outs("R1 reset state", O_IDLE);

    // R2/R3/R4/R5: exhaustive sweep of one source against one producer
    for (int s = 0; s < 2; s++)
      for (int st = 0; st < 2; st++)
        for (int rs = 0; rs < 32; rs++)
          for (int rd = 0; rd < 32; rd++)
            for (int m = 0; m < 4; m++) begin
              bit en = m[0];
              bit we = m[1];
              bit exp_stall = en && we && (rd != 0) && (rs == rd);
              string tag;
              @(negedge clk);
              quiet();
              if (s == 0) begin src_a_idx = 5'(rs); src_a_en = en; end
              else        begin src_b_idx = 5'(rs); src_b_en = en; end
              if (st == 0) begin ex_dst_idx = 5'(rd);  ex_dst_wen = we; end
              else         begin mem_dst_idx = 5'(rd); mem_dst_wen = we; end
              if (rd == 0)       tag = "R4 zero register";
              else if (!exp_stall) tag = "R5 no dependency";
              else if (st == 0)  tag = "R2 execute producer";
              else               tag = "R3 memory producer";
              #1 chk_outs(tag, exp_stall ? O_DATA : O_IDLE);
            end

    // R6: consumer behind a producer: two stall cycles, then issue
    @(negedge clk); quiet();
    src_a_idx = 5'd5; src_a_en = 1'b1; ex_dst_idx = 5'd5; ex_dst_wen = 1'b1;
    #1 chk_outs("R6 first bubble", O_DATA);
    @(negedge clk);
    ex_dst_wen = 1'b0; ex_dst_idx = '0; mem_dst_idx = 5'd5; mem_dst_wen = 1'b1;
    #1 chk_outs("R6 second bubble", O_DATA);
    @(negedge clk);
    mem_dst_wen = 1'b0; mem_dst_idx = '0;
    #1 chk_outs("R6 issue after write-back", O_IDLE);

    // R7/R8: plain branch
    @(negedge clk); quiet(); id_branch = 1'b1;
    #1 chk_outs("R7 branch in decode", O_BRANCH);
    @(negedge clk); id_branch = 1'b0;
    #1 chk_outs("R8 branch in execute", O_BRANCH);
    @(negedge clk);
    #1 chk_outs("R8 shadow ends", O_IDLE);

    // R9: branch in decode waiting on a data hazard
    @(negedge clk); quiet(); id_branch = 1'b1;
    src_b_idx = 5'd3; src_b_en = 1'b1; ex_dst_idx = 5'd3; ex_dst_wen = 1'b1;
    #1 chk_outs("R9 stall beats branch", O_DATA);
    @(negedge clk);
    ex_dst_wen = 1'b0; mem_dst_idx = 5'd3; mem_dst_wen = 1'b1;
    #1 chk_outs("R9 stall beats branch, no shadow yet", O_DATA);
    @(negedge clk); mem_dst_wen = 1'b0;
    #1 chk_outs("R9 branch leaves decode", O_BRANCH);
    @(negedge clk); quiet();
    #1 chk_outs("R9 branch in execute", O_BRANCH);
    @(negedge clk);
    #1 chk_outs("R9 shadow ends", O_IDLE);

    // R10: whole programs against sequential execution
    for (int p = 0; p < NPROG; p++) begin
      @(negedge clk);
      quiet();
      gen_prog();
      run_iss();
      run_pipe();
      for (int r = 0; r < 8; r++)
        chk(rf[r] == gold[r], $sformatf("R10 prog %0d reg %0d", p, r),
            {16'd0, rf[r]}, {16'd0, gold[r]});
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule